// File: doc/BRIEF.md
# PHY Management Register Bridge

The bridge lets a host reach the 16-bit registers of an external PHY through a handful of byte-wide local registers. The host loads a 5-bit PHY register number, then either writes a 16-bit value or requests a read. The bridge serialises each access onto a two-wire management link: a clock it derives from the system clock and a bidirectional data line. Read results come back into a pair of byte registers.

A write starts by itself once the high write-data byte is stored, so the low byte must be written first. A read starts when the host sets the read-request bit. The host polls the busy flag in the status register, clears the read bit itself, and then fetches the result. A scan-request bit keeps reads of the selected register running back to back, so the read-data pair always holds a recent value.

Every frame on the link is 64 bits long: 32 ones, start pattern 01, a 2-bit opcode, the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround, and 16 data bits, most significant bit first.

Top module: `mdio_mgmt_bridge`

## Requirements
- R1: After reset all local registers and status bits read zero, the management clock is low and the data line is not driven.
- R2: A write frame carries 32 ones, then 01, opcode 01, the PHY address, the register number, turnaround 10 and the 16 write-data bits MSB first. The data line is driven for all 64 bits.
- R3: Writing the low write-data byte alone starts no frame. Storing the high byte while idle starts a write of {high, low}.
- R4: A read frame carries opcode 10. The bridge drives the line only up to the register number and releases it from the first turnaround bit onward. The 16 bits it samples on the rising clock edges of the data field land in read-data low (bits 7:0) and high (bits 15:8).
- R5: Setting command bit 0 from 0 to 1 while idle starts one read. Busy (status bit 0) stays high until the result is stored. Bit 0 then stays set until the host clears it, and rewriting a 1 over a set bit starts nothing.
- R6: Status bit 2 (result not yet valid) rises when a read or a scan is requested and falls when a read result is stored.
- R7: The management clock is low between frames. During a frame each of its half periods lasts CLK_DIV system cycles.
- R8: While busy, writes to the address and write-data registers are ignored, and a command write can only clear bits, never set them.
- R9: Command bit 1 starts continuous reads of the selected register. Status bits 0 and 1 stay high and the read-data pair is refreshed after every frame. Clearing the bit stops the scan once the current frame ends.
- R10: Local offsets are: 0 register number (bits 4:0), 1 write-data low, 2 write-data high, 3 read-data low, 4 read-data high, 5 command, 6 status. Offsets 0, 1, 2 and 5 read back what was stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Local register write strobe |
| reg_addr | input | 3 | Local register offset for write and read |
| reg_wdata | input | 8 | Local register write data |
| reg_rdata | output | 8 | Local register read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | High while the bridge drives the data line |
| mdio_in | input | 1 | Management data sampled from the line |

## Verification
The assertions check on every cycle that the management clock stays low outside a frame and moves only on divider ticks. They also check that the line is released mid-frame only during reads, that the register number holds while busy, that the not-valid flag rises only together with busy, and that a lone low-byte write leaves the bridge idle. Frame contents, the returned read data, the half-period length, the rule that a command can only clear bits while busy, and scan refresh and termination need a PHY model on the serial side. Only the bench's directed scenarios can show these.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int HOST_AW   = 3;
    localparam int HOST_DW   = 8;
    localparam int PHY_AW    = 5;
    localparam int PHY_DW    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + 2 + 2 + 2 * PHY_AW;
    localparam int DATA_POS  = TA_POS + 2;

    typedef enum logic [HOST_AW-1:0] {
        RA_REGNUM = 3'd0,
        RA_WLO    = 3'd1,
        RA_WHI    = 3'd2,
        RA_RLO    = 3'd3,
        RA_RHI    = 3'd4,
        RA_CMD    = 3'd5,
        RA_STAT   = 3'd6
    } host_reg_e;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e          op;
        logic [PHY_AW-1:0] phy;
        logic [PHY_AW-1:0] regad;
        logic [PHY_DW-1:0] wdata;
        logic              scan;
    } mgmt_req_t;

    function automatic logic [FRAME_LEN-1:0] frame_of(mgmt_req_t r);
        logic [1:0]        ta;
        logic [PHY_DW-1:0] d;
        ta = (r.op == OP_WR) ? 2'b10 : 2'b11;
        d  = (r.op == OP_WR) ? r.wdata : {PHY_DW{1'b1}};
        return {{PRE_LEN{1'b1}}, 2'b01, r.op, r.phy, r.regad, ta, d};
    endfunction

    function automatic logic drives_bit(mgmt_op_e op, logic [IDX_W-1:0] idx);
        return (op == OP_WR) || (idx < IDX_W'(TA_POS));
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mgmt_req_t         req,
    input  logic              tick,
    input  logic              mdio_in,
    output logic              active,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic              cur_scan,
    output logic              cur_read,
    output logic [PHY_DW-1:0] rx_data
);
    logic [FRAME_LEN-1:0] sr;
    logic [IDX_W-1:0]     idx;
    mgmt_op_e             op_q;
    logic                 scan_q;
    logic [PHY_DW-1:0]    rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            mdc     <= 1'b0;
            idx     <= '0;
            sr      <= '0;
            op_q    <= OP_WR;
            scan_q  <= 1'b0;
            rx_q    <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    mdc    <= 1'b0;
                    idx    <= '0;
                    sr     <= frame_of(req);
                    op_q   <= req.op;
                    scan_q <= req.scan;
                end
            end else if (tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                    if (idx >= IDX_W'(DATA_POS)) begin
                        rx_q <= {rx_q[PHY_DW-2:0], mdio_in};
                    end
                end else begin
                    mdc <= 1'b0;
                    sr  <= {sr[FRAME_LEN-2:0], 1'b0};
                    if (idx == IDX_W'(FRAME_LEN - 1)) begin
                        active  <= 1'b0;
                        rd_done <= (op_q == OP_RD);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign mdio_out = active & sr[FRAME_LEN-1];
    assign mdio_oe  = active & drives_bit(op_q, idx);
    assign cur_scan = active & scan_q;
    assign cur_read = active & (op_q == OP_RD);
    assign rx_data  = rx_q;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_bridge_pkg::*;
#(
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] wdata,
    output logic [HOST_DW-1:0] rdata,
    input  logic               eng_active,
    input  logic               eng_scan,
    input  logic               rd_done,
    input  logic [PHY_DW-1:0]  rx_data,
    output logic               start,
    output mgmt_req_t          req,
    output logic               busy,
    output logic               nvalid
);
    logic [PHY_AW-1:0]  ra_q;
    logic [HOST_DW-1:0] wlo_q, whi_q, rlo_q, rhi_q;
    logic               cmd_rd, cmd_scan;
    logic               wr_pend, rd_pend;
    logic               scan_act;
    host_reg_e          sel;

    assign sel      = host_reg_e'(addr);
    assign busy     = eng_active | wr_pend | rd_pend | cmd_scan | rd_done;
    assign scan_act = cmd_scan | eng_scan;
    assign start    = !eng_active && !rd_done && (wr_pend || rd_pend || cmd_scan);

    always_comb begin
        req.op    = wr_pend ? OP_WR : OP_RD;
        req.phy   = PHY_ADDR;
        req.regad = ra_q;
        req.wdata = {whi_q, wlo_q};
        req.scan  = !wr_pend && !rd_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q     <= '0;
            wlo_q    <= '0;
            whi_q    <= '0;
            rlo_q    <= '0;
            rhi_q    <= '0;
            cmd_rd   <= 1'b0;
            cmd_scan <= 1'b0;
            wr_pend  <= 1'b0;
            rd_pend  <= 1'b0;
            nvalid   <= 1'b0;
        end else begin
            if (start) begin
                if (wr_pend) begin
                    wr_pend <= 1'b0;
                end else if (rd_pend) begin
                    rd_pend <= 1'b0;
                end
            end
            if (rd_done) begin
                rlo_q  <= rx_data[HOST_DW-1:0];
                rhi_q  <= rx_data[PHY_DW-1:HOST_DW];
                nvalid <= 1'b0;
            end
            if (we) begin
                case (sel)
                    RA_REGNUM: if (!busy) ra_q  <= wdata[PHY_AW-1:0];
                    RA_WLO:    if (!busy) wlo_q <= wdata;
                    RA_WHI: begin
                        if (!busy) begin
                            whi_q   <= wdata;
                            wr_pend <= 1'b1;
                        end
                    end
                    RA_CMD: begin
                        if (!busy) begin
                            cmd_rd   <= wdata[0];
                            cmd_scan <= wdata[1];
                            if (wdata[0] && !cmd_rd) begin
                                rd_pend <= 1'b1;
                                nvalid  <= 1'b1;
                            end
                            if (wdata[1] && !cmd_scan) begin
                                nvalid <= 1'b1;
                            end
                        end else begin
                            cmd_rd   <= cmd_rd & wdata[0];
                            cmd_scan <= cmd_scan & wdata[1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            RA_REGNUM: rdata = {{(HOST_DW-PHY_AW){1'b0}}, ra_q};
            RA_WLO:    rdata = wlo_q;
            RA_WHI:    rdata = whi_q;
            RA_RLO:    rdata = rlo_q;
            RA_RHI:    rdata = rhi_q;
            RA_CMD:    rdata = {{(HOST_DW-2){1'b0}}, cmd_scan, cmd_rd};
            RA_STAT:   rdata = {{(HOST_DW-3){1'b0}}, nvalid, scan_act, busy};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_bridge.sv
module mdio_mgmt_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int                CLK_DIV  = 4,
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [HOST_AW-1:0] reg_addr,
    input  logic [HOST_DW-1:0] reg_wdata,
    output logic [HOST_DW-1:0] reg_rdata,
    output logic               mdc,
    output logic               mdio_out,
    output logic               mdio_oe,
    input  logic               mdio_in
);
    mgmt_req_t         req_w;
    logic              start_w, tick_w, eng_active, eng_scan, eng_read, rd_done_w;
    logic              busy_w, nvalid_w;
    logic [PHY_DW-1:0] rx_w;

    mdio_host_regs #(.PHY_ADDR(PHY_ADDR)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .eng_active (eng_active),
        .eng_scan   (eng_scan),
        .rd_done    (rd_done_w),
        .rx_data    (rx_w),
        .start      (start_w),
        .req        (req_w),
        .busy       (busy_w),
        .nvalid     (nvalid_w)
    );

    mdio_clk_div #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_active),
        .tick (tick_w)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .req      (req_w),
        .tick     (tick_w),
        .mdio_in  (mdio_in),
        .active   (eng_active),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done_w),
        .cur_scan (eng_scan),
        .cur_read (eng_read),
        .rx_data  (rx_w)
    );
endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk
    import mdio_bridge_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [HOST_AW-1:0] reg_addr,
    input logic               busy,
    input logic               nvalid,
    input logic               eng_active,
    input logic               eng_read,
    input logic               tick,
    input logic               mdc,
    input logic               mdio_oe,
    input logic [PHY_AW-1:0]  cur_regad
);
    // R7
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_active |-> !mdc);

    // R7
    mdc_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc != $past(mdc)) |-> ($past(tick) || !$past(eng_active)));

    // R4
    release_only_read_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_active && $past(eng_active) && $fell(mdio_oe)) |-> eng_read);

    // R8
    regnum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we && reg_addr == RA_REGNUM) |=> $stable(cur_regad));

    // R6
    nvalid_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nvalid) |-> busy);

    // R3
    low_byte_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_we && reg_addr == RA_WLO) |=> !busy);
endmodule

bind mdio_mgmt_bridge mdio_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .busy       (busy_w),
    .nvalid     (nvalid_w),
    .eng_active (eng_active),
    .eng_read   (eng_read),
    .tick       (tick_w),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe),
    .cur_regad  (req_w.regad)
);

// File: tb/tb_mdio_mgmt_bridge.sv
module tb_mdio_mgmt_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam logic [4:0] PHY = 5'd3;
    localparam logic [2:0] A_NUM = 3'd0, A_WLO = 3'd1, A_WHI = 3'd2, A_RLO = 3'd3,
                           A_RHI = 3'd4, A_CMD = 3'd5, A_STAT = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic mdc, mdio_out, mdio_oe;
    logic mdio_in = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    int k = 0;
    int frames = 0;
    logic [63:0] cap = '0, cap_oe = '0, last_frame = '0, last_oe = '0;
    logic [15:0] phy_data = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_bridge #(.CLK_DIV(DIV), .PHY_ADDR(PHY)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: samples on rising edges, answers on falling edges
    always @(posedge mdc) begin
        cap[63-k]    = mdio_out;
        cap_oe[63-k] = mdio_oe;
        if (k == 63) begin
            last_frame = cap;
            last_oe    = cap_oe;
            frames     = frames + 1;
            k          = 0;
        end else begin
            k = k + 1;
        end
    end

    always @(negedge mdc) begin
        if (cap[29:28] == 2'b10 && k == 47)
            mdio_in = 1'b0;
        else if (cap[29:28] == 2'b10 && k >= 48)
            mdio_in = phy_data[63-k];
        else
            mdio_in = 1'b1;
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(A_STAT, s);
            if (!s[0]) return;
        end
    endtask

    task automatic wait_frames(input int target);
        while (frames < target) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_STAT, v); chk("R1 status", v, 8'h00);
        rd(A_RLO, v);  chk("R1 rdata lo", v, 8'h00);
        rd(A_RHI, v);  chk("R1 rdata hi", v, 8'h00);
        rd(A_CMD, v);  chk("R1 command", v, 8'h00);
        rd(A_NUM, v);  chk("R1 regnum", v, 8'h00);
        chk("R1 mdc/oe idle", {mdc, mdio_oe}, 2'b00);
    endtask

    task automatic t_write();
        logic [7:0] v;
        longint t1, t2;
        int f0;
        f0 = frames;
        wr(A_NUM, 8'h0A);
        wr(A_WLO, 8'h34);
        rd(A_STAT, v); chk("R3 low byte alone idle", v, 8'h00);
        wr(A_WHI, 8'h12);
        rd(A_STAT, v); chk("R3 high byte starts busy", v, 8'h01);
        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        chk("R7 mdc period", t2 - t1, 2 * DIV * CLK_PERIOD);
        wr(A_NUM, 8'h1F);
        wr(A_WLO, 8'h99);
        wr(A_WHI, 8'h77);
        wait_idle();
        chk("R3 one frame", frames - f0, 1);
        chk("R2 write frame", last_frame,
            {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, 5'h0A, 2'b10, 16'h1234});
        chk("R2 driven all bits", last_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_NUM, v); chk("R8/R10 regnum kept", v, 8'h0A);
        rd(A_WLO, v); chk("R8/R10 wlo kept", v, 8'h34);
        rd(A_WHI, v); chk("R8/R10 whi kept", v, 8'h12);
        chk("R7 mdc low idle", mdc, 1'b0);
    endtask

    task automatic t_read();
        logic [7:0] v;
        int f0;
        phy_data = 16'hBEEF;
        wr(A_CMD, 8'h01);
        rd(A_STAT, v); chk("R5/R6 busy and not valid", v, 8'h05);
        wait_idle();
        chk("R4 read header", last_frame[63:18],
            {32'hFFFF_FFFF, 2'b01, 2'b10, PHY, 5'h0A});
        chk("R4 released from turnaround", last_oe[17:0], 18'h0);
        chk("R4 driven before turnaround", last_oe[63:18], {46{1'b1}});
        rd(A_RLO, v); chk("R4 rdata lo", v, 8'hEF);
        rd(A_RHI, v); chk("R4 rdata hi", v, 8'hBE);
        rd(A_STAT, v); chk("R6 valid after read", v, 8'h00);
        rd(A_CMD, v); chk("R5 read bit held", v, 8'h01);
        f0 = frames;
        wr(A_CMD, 8'h01);
        repeat (200) @(negedge clk);
        chk("R5 no restart while set", frames - f0, 0);
        wr(A_CMD, 8'h00);
    endtask

    task automatic t_busy_cmd();
        logic [7:0] v;
        wr(A_CMD, 8'h01);
        wr(A_CMD, 8'h03);
        rd(A_CMD, v); chk("R8 cannot set while busy", v, 8'h01);
        wr(A_CMD, 8'h00);
        rd(A_CMD, v); chk("R8 clear while busy", v, 8'h00);
        wait_idle();
        rd(A_STAT, v); chk("R8 idle after cleared read", v, 8'h00);
    endtask

    task automatic t_scan();
        logic [7:0] v;
        int f0;
        phy_data = 16'h1357;
        wr(A_NUM, 8'h05);
        wr(A_CMD, 8'h02);
        rd(A_STAT, v); chk("R9/R6 scan status", v, 8'h07);
        f0 = frames;
        wait_frames(f0 + 1);
        phy_data = 16'h2468;
        f0 = frames;
        wait_frames(f0 + 1);
        repeat (4 * DIV) @(negedge clk);
        rd(A_RLO, v); chk("R9 refreshed lo", v, 8'h68);
        rd(A_RHI, v); chk("R9 refreshed hi", v, 8'h24);
        rd(A_STAT, v); chk("R9/R6 scanning valid", v, 8'h03);
        chk("R9 scan header", last_frame[63:18],
            {32'hFFFF_FFFF, 2'b01, 2'b10, PHY, 5'h05});
        wr(A_CMD, 8'h00);
        f0 = frames;
        wait_idle();
        chk("R9 stops after current frame", (frames - f0 <= 1) ? 1 : 0, 1);
        rd(A_STAT, v); chk("R9 scan ended", v, 8'h00);
        chk("R7 idle line", {mdc, mdio_oe}, 2'b00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_read();
        t_busy_cmd();
        t_scan();
        summary();
        $finish;
    end
endmodule